// File: doc/BRIEF.md
# Write-Start Guard for a Nonvolatile Memory

This block sits between the raw control strobes of a nonvolatile memory and its programming controller, and decides on every clock edge whether a write may start. It combines four independent inhibits into one registered write-permit output. The first is a supply inhibit, driven by a single digital supply-good input that stands in for the analog level detector. The second is a hold-off timer that keeps writes blocked for a set time after the supply becomes good. The third is a static check of the strobe levels. The fourth is a minimum-width filter on the chip-enable and write-enable strobes, so that short glitches cannot begin a programming cycle.

All strobes are active low. The input strobes are assumed to be synchronous to the block clock. The chip-enable and write-enable strobes each pass through a run-length filter, and the filtered versions are brought out so that the controller can use them. The hold-off time and the minimum low width are parameters counted in clock cycles. Write-permit is registered and changes on the same clock edge as the filtered strobes.

Top module: `write_guard`

## Requirements
- R1: When `supply_ok` (active high) is sampled low at a clock edge, `write_permit` is 0 after that edge.
- R2: `write_permit` can be 1 only from the edge at which `supply_ok` has been sampled high on `HOLDOFF_CYC` consecutive edges, and not before.
- R3: When `oe_n_raw` (active low) is sampled low, `write_permit` is 0 after that edge. Once it is high again and all other conditions hold, the permit returns on that same edge.
- R4: When `ce_n_raw` or `we_n_raw` is sampled high (1 = deasserted), the matching filtered strobe is 1 and `write_permit` is 0 after that same edge.
- R5: A filtered strobe (`ce_filt_n` or `we_filt_n`, 0 = asserted) goes to 0 only at the edge that samples its raw strobe low for the `MIN_LOW_CYC`-th consecutive time. A low pulse shorter than that leaves the filtered strobe and `write_permit` unchanged.
- R6: Any edge that samples `supply_ok` low restarts the hold-off. After the supply returns, a full `HOLDOFF_CYC` consecutive good samples are needed again.
- R7: While `rst_n` is low, and on the first edge out of reset, `ce_filt_n` = 1, `we_filt_n` = 1 and `write_permit` = 0.
- R8: After each edge, `write_permit` is 1 exactly when the hold-off has been met, both filtered strobes are asserted and `oe_n_raw` was sampled high, all evaluated at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Digital supply-good indication, 1 = supply above threshold |
| ce_n_raw | input | 1 | Raw chip enable, active low |
| we_n_raw | input | 1 | Raw write enable, active low |
| oe_n_raw | input | 1 | Raw output enable, active low |
| ce_filt_n | output | 1 | Width-filtered chip enable, active low |
| we_filt_n | output | 1 | Width-filtered write enable, active low |
| write_permit | output | 1 | Registered permission to start a write, active high |

## Verification
Directed sequences apply each inhibit on its own while every other condition is satisfied. The supply is held good for one cycle fewer than, and then exactly, the hold-off. The supply is dropped for a single cycle in the middle of a valid write. Output enable is pulled low for one cycle. Strobe pulses are made one cycle shorter than, and exactly equal to, the minimum width. Each of these patterns separates an off-by-one in one counter from a correct boundary, and shows which inhibit fails to gate the permit. Random stimulus then mixes rare supply dropouts with strobe runs of varied length. These runs reach combinations such as both strobes crossing the width limit on the same edge, or the hold-off ending in the middle of a low strobe.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;

  // Strobes that pass through the width filter, in vector order.
  typedef enum int unsigned {
    STB_CE = 0,
    STB_WE = 1
  } wg_stb_e;

  localparam int unsigned WG_NUM_STB = 2;

  // Width of a saturating run counter that must reach 'limit'.
  function automatic int unsigned wg_cnt_w(input int unsigned limit);
    if (limit < 2) return 1;
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/wg_holdoff_timer.sv
`timescale 1ns/1ps
module wg_holdoff_timer
  import wg_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic ready_nxt,
  output logic ready_q
);

  localparam int unsigned CW = wg_cnt_w(HOLDOFF_CYC);
  localparam logic [CW-1:0] LIM = CW'(HOLDOFF_CYC);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  // Saturating count of consecutive good-supply samples.
  function automatic logic [CW-1:0] good_run_next(input logic [CW-1:0] cur,
                                                  input logic live);
    if (!live) return '0;
    if (cur == LIM) return cur;
    return cur + 1'b1;
  endfunction

  always_comb begin
    run_d     = good_run_next(run_q, supply_ok);
    ready_nxt = (run_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      ready_q <= ready_nxt;
    end
  end

  initial assert (HOLDOFF_CYC >= 1) else $error("HOLDOFF_CYC must be at least 1");

  // R6: a bad supply sample clears the hold-off status
  assert_holdoff_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !ready_q);

  // R2: the hold-off only completes on a good supply sample
  assert_holdoff_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(supply_ok));

endmodule

// File: rtl/wg_strobe_filter.sv
`timescale 1ns/1ps
module wg_strobe_filter
  import wg_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic asserted_nxt,
  output logic filt_n
);

  localparam int unsigned CW = wg_cnt_w(MIN_LOW_CYC);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW_CYC);

  logic [CW-1:0] low_run_q;
  logic [CW-1:0] low_run_d;

  // Saturating count of consecutive low samples of the raw strobe.
  function automatic logic [CW-1:0] low_run_next(input logic [CW-1:0] cur,
                                                 input logic is_low);
    if (!is_low) return '0;
    if (cur == LIM) return cur;
    return cur + 1'b1;
  endfunction

  always_comb begin
    low_run_d    = low_run_next(low_run_q, !raw_n);
    asserted_nxt = (low_run_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
      filt_n    <= 1'b1;
    end else begin
      low_run_q <= low_run_d;
      filt_n    <= !asserted_nxt;
    end
  end

  initial assert (MIN_LOW_CYC >= 1) else $error("MIN_LOW_CYC must be at least 1");

  // R4: a high raw sample releases the filtered strobe on that edge
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_n |=> filt_n);

  // R5: the filtered strobe only falls on a low raw sample
  assert_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_n) |-> !$past(raw_n));

endmodule

// File: rtl/wg_permit_gate.sv
`timescale 1ns/1ps
module wg_permit_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic holdoff_ok_nxt,
  input  logic oe_n_raw,
  input  logic ce_ok_nxt,
  input  logic we_ok_nxt,
  output logic permit_q
);

  logic permit_d;

  // All inhibits must be clear at the same edge.
  function automatic logic permit_rule(input logic sup, input logic hold,
                                       input logic oe_n, input logic ce,
                                       input logic we);
    return sup & hold & oe_n & ce & we;
  endfunction

  always_comb permit_d = permit_rule(supply_ok, holdoff_ok_nxt, oe_n_raw,
                                     ce_ok_nxt, we_ok_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) permit_q <= 1'b0;
    else        permit_q <= permit_d;
  end

  // R1: a bad supply sample removes the permit on that edge
  assert_supply_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !permit_q);

  // R3: output enable low blocks the permit
  assert_oe_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_raw |=> !permit_q);

endmodule

// File: rtl/write_guard.sv
`timescale 1ns/1ps
module write_guard
  import wg_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 1_000_000,
  parameter int unsigned MIN_LOW_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ce_n_raw,
  input  logic we_n_raw,
  input  logic oe_n_raw,
  output logic ce_filt_n,
  output logic we_filt_n,
  output logic write_permit
);

  logic                  holdoff_ok_nxt;
  logic                  holdoff_ready;
  logic [WG_NUM_STB-1:0] stb_raw_n;
  logic [WG_NUM_STB-1:0] stb_ok_nxt;
  logic [WG_NUM_STB-1:0] stb_filt_n;

  assign stb_raw_n[STB_CE] = ce_n_raw;
  assign stb_raw_n[STB_WE] = we_n_raw;

  wg_holdoff_timer #(
    .HOLDOFF_CYC (HOLDOFF_CYC)
  ) u_holdoff (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .ready_nxt (holdoff_ok_nxt),
    .ready_q   (holdoff_ready)
  );

  for (genvar gi = 0; gi < WG_NUM_STB; gi++) begin : g_flt
    wg_strobe_filter #(
      .MIN_LOW_CYC (MIN_LOW_CYC)
    ) u_flt (
      .clk          (clk),
      .rst_n        (rst_n),
      .raw_n        (stb_raw_n[gi]),
      .asserted_nxt (stb_ok_nxt[gi]),
      .filt_n       (stb_filt_n[gi])
    );
  end

  wg_permit_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .holdoff_ok_nxt (holdoff_ok_nxt),
    .oe_n_raw       (oe_n_raw),
    .ce_ok_nxt      (stb_ok_nxt[STB_CE]),
    .we_ok_nxt      (stb_ok_nxt[STB_WE]),
    .permit_q       (write_permit)
  );

  assign ce_filt_n = stb_filt_n[STB_CE];
  assign we_filt_n = stb_filt_n[STB_WE];

  // R8: a permit implies both filtered strobes are asserted
  assert_permit_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_permit |-> (!ce_filt_n && !we_filt_n));

  // R2: a permit implies the hold-off has completed
  assert_permit_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    write_permit |-> holdoff_ready);

  // R4: a high raw write enable removes the permit on that edge
  assert_we_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_n_raw |=> !write_permit);

endmodule

// File: tb/write_guard_tb.sv
`timescale 1ns/1ps
module write_guard_tb;

  localparam int H = 40;
  localparam int M = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic ce_n_raw = 1'b1;
  logic we_n_raw = 1'b1;
  logic oe_n_raw = 1'b1;
  logic ce_filt_n, we_filt_n, write_permit;

  int n_chk = 0;
  int n_bad = 0;
  int sup_run = 0, ce_run = 0, we_run = 0;
  logic exp_perm = 1'b0;

  always #2.5 clk = ~clk;

  write_guard #(.HOLDOFF_CYC(H), .MIN_LOW_CYC(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .ce_n_raw(ce_n_raw), .we_n_raw(we_n_raw), .oe_n_raw(oe_n_raw),
    .ce_filt_n(ce_filt_n), .we_filt_n(we_filt_n), .write_permit(write_permit)
  );

  function automatic int run_after(int cur, bit live, int lim);
    if (!live) return 0;
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // One clock: drive at the falling edge, update model, compare after rise.
  task automatic step(bit sup, bit ce_n, bit we_n, bit oe_n);
    @(negedge clk);
    supply_ok = sup; ce_n_raw = ce_n; we_n_raw = we_n; oe_n_raw = oe_n;
    @(posedge clk);
    #1;
    sup_run = run_after(sup_run, sup, H);
    ce_run  = run_after(ce_run, !ce_n, M);
    we_run  = run_after(we_run, !we_n, M);
    exp_perm = (sup_run >= H) && (ce_run >= M) && (we_run >= M) && oe_n;
    chk("R5", "ce_filt_n", ce_filt_n, !(ce_run >= M));
    chk("R5", "we_filt_n", we_filt_n, !(we_run >= M));
    chk("R8", "write_permit", write_permit, exp_perm);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    bit sup, ce_n, we_n, oe_n;
    int drop_left;
    seed_dummy = $urandom(32'h5EED_0042);

    // R7: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "ce_filt_n", ce_filt_n, 1'b1);
    chk("R7", "we_filt_n", we_filt_n, 1'b1);
    chk("R7", "write_permit", write_permit, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R7", "write_permit first edge", write_permit, 1'b0);

    // R2: hold-off boundary with all strobes valid
    for (int i = 0; i < H - 1; i++) step(1, 0, 0, 1);
    chk("R2", "permit one short of hold-off", write_permit, 1'b0);
    step(1, 0, 0, 1);
    chk("R2", "permit at hold-off", write_permit, 1'b1);

    // R1 / R6: single-cycle dropout, then full hold-off again
    step(0, 0, 0, 1);
    chk("R1", "permit after supply drop", write_permit, 1'b0);
    for (int i = 0; i < H - 1; i++) step(1, 0, 0, 1);
    chk("R6", "permit one short after restart", write_permit, 1'b0);
    step(1, 0, 0, 1);
    chk("R6", "permit after restarted hold-off", write_permit, 1'b1);

    // R3: output enable low
    step(1, 0, 0, 0);
    chk("R3", "permit with oe low", write_permit, 1'b0);
    step(1, 0, 0, 1);
    chk("R3", "permit with oe high again", write_permit, 1'b1);

    // R4 / R5: write enable high, then exactly-min and short pulses
    step(1, 0, 1, 1);
    chk("R4", "we_filt_n on we high", we_filt_n, 1'b1);
    chk("R4", "permit on we high", write_permit, 1'b0);
    for (int i = 0; i < M - 1; i++) step(1, 0, 0, 1);
    chk("R5", "we_filt_n one short", we_filt_n, 1'b1);
    chk("R5", "permit one short", write_permit, 1'b0);
    step(1, 0, 0, 1);
    chk("R5", "we_filt_n at min width", we_filt_n, 1'b0);
    chk("R5", "permit at min width", write_permit, 1'b1);

    step(1, 1, 0, 1);
    chk("R4", "permit on ce high", write_permit, 1'b0);
    for (int i = 0; i < M - 1; i++) step(1, 0, 0, 1);
    step(1, 1, 0, 1);
    chk("R5", "ce_filt_n after short glitch", ce_filt_n, 1'b1);
    chk("R5", "permit after short glitch", write_permit, 1'b0);

    // Random mix
    sup = 1; ce_n = 1; we_n = 1; oe_n = 1; drop_left = 0;
    for (int i = 0; i < 4000; i++) begin
      if (drop_left > 0) begin
        drop_left--;
        sup = (drop_left == 0);
      end else if ($urandom_range(299) == 0) begin
        drop_left = $urandom_range(3, 1);
        sup = 0;
      end
      if ($urandom_range(5) == 0) ce_n = !ce_n;
      if ($urandom_range(5) == 0) we_n = !we_n;
      oe_n = ($urandom_range(9) != 0);
      step(sup, ce_n, we_n, oe_n);
    end

    summary();
    $finish;
  end

endmodule